// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is the per-output logic cell that sits behind one OR sum of a sum-of-products array. It collects a parameterized group of product terms into a single sum. It passes that sum either straight through or through a D flip-flop, and then applies a selectable output polarity. The result drives a tri-state pin whose enable is one dedicated product term. A second selector returns a feedback signal to the array. That feedback comes from the stored register value, the true (uninverted) sum, or the level seen on the pin.

Four stored configuration bits set the cell's mode. Bit 0 selects polarity: 1 means active-high and 0 means active-low. Bit 1 selects the path: 1 means combinational and 0 means registered. Bits 3:2 select the feedback source. The flip-flop is clocked by a clock term shared across the array. It is set by a shared synchronous preset term and emptied by a shared asynchronous clear term. The pin is modelled as three separate ports: output value, output enable and input value.

Top module: `sop_out_cell`

## Requirements
- R1: The sum is the OR of all product-term inputs `pterm`. With configuration 4'b0011 (combinational, active-high, native feedback), `pin_out` equals that OR in the same cycle, including when only the highest-numbered term is set.
- R2: With bit 1 = 1 (combinational), `pin_out` equals the sum when bit 0 = 1 and the inverted sum when bit 0 = 0.
- R3: With bit 1 = 0 (registered), `pin_out` shows the flip-flop contents, inverted when bit 0 = 0. On a rising `clk`, with `aclr` and `spre` low, the flip-flop loads the uninverted sum.
- R4: When `spre` is high at a rising `clk` and `aclr` is low, the flip-flop holds 1 after the edge.
- R5: While `aclr` is high, the flip-flop reads 0 at once, without waiting for a clock edge.
- R6: When `aclr` and `spre` are both high across a rising `clk`, the flip-flop holds 0.
- R7: `pin_oe` equals `oe_term` in every configuration.
- R8: With bits 3:2 = 2'b01, `fb` equals `pin_in`, including while `pin_oe` is low.
- R9: With bits 3:2 = 2'b10, `fb` equals the uninverted sum, whatever the polarity and path.
- R10: With bits 3:2 = 2'b00, `fb` is the flip-flop contents in registered mode and `pin_in` in combinational mode.
- R11: Bits 3:2 = 2'b11 behaves as pin feedback, the same as 2'b01.
- R12: Configuration 4'b0000 gives registered, active-low output with register feedback. After a clear, it drives `pin_out` = 1 and `fb` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock term for the flip-flop |
| aclr | input | 1 | Shared asynchronous clear term, active high |
| spre | input | 1 | Shared synchronous preset term, active high |
| cfg | input | 4 | Stored configuration: [0] polarity, [1] path, [3:2] feedback source |
| pterm | input | NUM_PT | Product terms ORed into this cell's sum |
| oe_term | input | 1 | Output-enable product term |
| pin_in | input | 1 | Level currently present on the pin |
| pin_out | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb | output | 1 | Feedback signal returned to the array |

## Verification
Four behaviours are checked by the assertions at every clock edge:
- the flip-flop loads the sum when no preset or clear is active;
- preset sets the flip-flop;
- a clear seen at an edge leaves the flip-flop empty;
- the combinational pin value and the sum and native-register feedback paths match the product terms.

Three behaviours can only be shown by the bench's scenarios: the flip-flop emptying in the middle of a cycle with no edge, clear taking priority over preset across an edge, and pin feedback returning an externally driven level while the driver is off. The random phase goes through every configuration value against a bench model of the flip-flop.

// File: rtl/sop_cell_pkg.sv
package sop_cell_pkg;

   localparam int CELL_CFG_W = 4;

   // Feedback source selection, held in configuration bits [3:2]
   typedef enum logic [1:0] {
      FB_NATIVE  = 2'b00,   // register when registered, pin when combinational
      FB_PIN     = 2'b01,
      FB_SUM     = 2'b10,
      FB_PIN_ALT = 2'b11
   } fb_sel_e;

   // Packed so that the field positions match the cfg port bits
   typedef struct packed {
      fb_sel_e fb;      // [3:2]
      logic    comb;    // [1]  1 = combinational path
      logic    act_hi;  // [0]  1 = active-high output
   } cell_cfg_t;

endpackage

// File: rtl/sop_or_sum.sv
module sop_or_sum #(
   parameter int NUM_PT  = 12,
   parameter int GROUP_W = 4,
   parameter bit GROUPED = 1'b1
) (
   input  logic [NUM_PT-1:0] pt,
   output logic              sum
);

   localparam int NGRP  = (NUM_PT + GROUP_W - 1) / GROUP_W;
   localparam int PAD_W = NGRP * GROUP_W;

   generate
      if (GROUPED) begin : g_grouped
         logic [PAD_W-1:0] padded;
         logic [NGRP-1:0]  grp;

         always_comb begin
            padded              = '0;
            padded[NUM_PT-1:0]  = pt;
         end

         for (genvar g = 0; g < NGRP; g++) begin : g_grp
            assign grp[g] = |padded[g*GROUP_W +: GROUP_W];
         end

         assign sum = |grp;
      end else begin : g_flat
         assign sum = |pt;
      end
   endgenerate

endmodule

// File: rtl/sop_cell_reg.sv
module sop_cell_reg (
   input  logic clk,
   input  logic aclr,
   input  logic spre,
   input  logic d,
   output logic q
);

   // Asynchronous clear outranks the synchronous preset
   always_ff @(posedge clk or posedge aclr) begin
      if (aclr)      q <= 1'b0;
      else if (spre) q <= 1'b1;
      else           q <= d;
   end

endmodule

// File: rtl/sop_out_sel.sv
module sop_out_sel (
   input  logic comb,
   input  logic act_hi,
   input  logic sum,
   input  logic q,
   output logic pin_val
);

   logic raw;

   always_comb begin
      raw     = comb ? sum : q;
      pin_val = act_hi ? raw : ~raw;
   end

endmodule

// File: rtl/sop_fb_sel.sv
module sop_fb_sel
   import sop_cell_pkg::*;
(
   input  fb_sel_e sel,
   input  logic    comb,
   input  logic    q,
   input  logic    sum,
   input  logic    pin_in,
   output logic    fb
);

   always_comb begin
      case (sel)
         FB_NATIVE:           fb = comb ? pin_in : q;
         FB_SUM:              fb = sum;
         FB_PIN, FB_PIN_ALT:  fb = pin_in;
         default:             fb = pin_in;
      endcase
   end

endmodule

// File: rtl/sop_out_cell.sv
module sop_out_cell
   import sop_cell_pkg::*;
#(
   parameter int NUM_PT  = 12,
   parameter int GROUP_W = 4,
   parameter bit GROUPED = 1'b1
) (
   input  logic                  clk,
   input  logic                  aclr,
   input  logic                  spre,
   input  logic [CELL_CFG_W-1:0] cfg,
   input  logic [NUM_PT-1:0]     pterm,
   input  logic                  oe_term,
   input  logic                  pin_in,
   output logic                  pin_out,
   output logic                  pin_oe,
   output logic                  fb
);

   generate
      if (NUM_PT < 1 || NUM_PT > 64) begin : g_bad_pt
         $error("sop_out_cell: NUM_PT must lie in 1..64");
      end
      if (GROUP_W < 1 || GROUP_W > NUM_PT) begin : g_bad_grp
         $error("sop_out_cell: GROUP_W must lie in 1..NUM_PT");
      end
   endgenerate

   cell_cfg_t c;
   logic      sum;
   logic      q_r;

   assign c = cell_cfg_t'(cfg);

   sop_or_sum #(
      .NUM_PT (NUM_PT),
      .GROUP_W(GROUP_W),
      .GROUPED(GROUPED)
   ) u_sum (
      .pt (pterm),
      .sum(sum)
   );

   sop_cell_reg u_reg (
      .clk (clk),
      .aclr(aclr),
      .spre(spre),
      .d   (sum),
      .q   (q_r)
   );

   sop_out_sel u_out (
      .comb   (c.comb),
      .act_hi (c.act_hi),
      .sum    (sum),
      .q      (q_r),
      .pin_val(pin_out)
   );

   sop_fb_sel u_fb (
      .sel   (c.fb),
      .comb  (c.comb),
      .q     (q_r),
      .sum   (sum),
      .pin_in(pin_in),
      .fb    (fb)
   );

   assign pin_oe = oe_term;

endmodule

// File: rtl/sop_out_cell_chk.sv
module sop_out_cell_chk #(
   parameter int NUM_PT = 12
) (
   input logic              clk,
   input logic              aclr,
   input logic              spre,
   input logic [3:0]        cfg,
   input logic [NUM_PT-1:0] pterm,
   input logic              pin_out,
   input logic              fb,
   input logic              q_r
);

   // R4
   preset_set_chk: assert property (@(posedge clk) disable iff (aclr)
      spre |=> q_r);

   // R3
   sum_capture_chk: assert property (@(posedge clk) disable iff (aclr)
      !spre |=> (q_r == $past(|pterm)));

   // R5
   clear_empty_chk: assert property (@(posedge clk)
      aclr |-> !q_r);

   // R2
   comb_pin_chk: assert property (@(posedge clk) disable iff (aclr)
      cfg[1] |-> (pin_out == ((|pterm) ~^ cfg[0])));

   // R10
   native_fb_chk: assert property (@(posedge clk) disable iff (aclr)
      (cfg[3:2] == 2'b00 && !cfg[1]) |-> (fb == q_r));

   // R9
   sum_fb_chk: assert property (@(posedge clk) disable iff (aclr)
      (cfg[3:2] == 2'b10) |-> (fb == |pterm));

endmodule

bind sop_out_cell sop_out_cell_chk #(.NUM_PT(NUM_PT)) u_chk (
   .clk    (clk),
   .aclr   (aclr),
   .spre   (spre),
   .cfg    (cfg),
   .pterm  (pterm),
   .pin_out(pin_out),
   .fb     (fb),
   .q_r    (q_r)
);

// File: tb/sop_out_cell_bench.sv
`timescale 1ns/1ps
module sop_out_cell_bench;

   localparam int NPT = 12;

   logic           clk = 1'b0;
   logic           aclr, spre, oe_term, pin_in;
   logic [3:0]     cfg;
   logic [NPT-1:0] pterm;
   logic           pin_out, pin_oe, fb;

   int  n_chk  = 0;
   int  n_fail = 0;
   logic mq;   // bench model of the flip-flop

   always #5 clk = ~clk;

   sop_out_cell #(.NUM_PT(NPT)) u_sop_out_cell (
      .clk(clk), .aclr(aclr), .spre(spre), .cfg(cfg), .pterm(pterm),
      .oe_term(oe_term), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
   );

   function automatic logic e_pin(logic [3:0] c, logic s, logic q);
      logic v;
      v = c[1] ? s : q;
      return c[0] ? v : ~v;
   endfunction

   function automatic logic e_fb(logic [3:0] c, logic s, logic q, logic p);
      case (c[3:2])
         2'b00:   return c[1] ? p : q;
         2'b10:   return s;
         default: return p;
      endcase
   endfunction

   task automatic chk(string tag, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b (cfg=%b pterm=%h)", tag, act, exp, cfg, pterm);
      end
   endtask

   task automatic check_all();
      logic s;
      s = |pterm;
      chk(cfg[1] ? "R2" : "R3", pin_out, e_pin(cfg, s, mq));
      chk("R7", pin_oe, oe_term);
      case (cfg[3:2])
         2'b00: chk("R10", fb, e_fb(cfg, s, mq, pin_in));
         2'b01: chk("R8",  fb, e_fb(cfg, s, mq, pin_in));
         2'b10: chk("R9",  fb, e_fb(cfg, s, mq, pin_in));
         default: chk("R11", fb, e_fb(cfg, s, mq, pin_in));
      endcase
   endtask

   // Called just after a negedge with inputs settled; ends at the next negedge
   task automatic tick();
      @(posedge clk);
      if (aclr)      mq = 1'b0;
      else if (spre) mq = 1'b1;
      else           mq = |pterm;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240917));
      aclr = 1'b1; spre = 1'b0; cfg = 4'b0000; pterm = '0;
      oe_term = 1'b0; pin_in = 1'b0; mq = 1'b0;
      @(negedge clk); @(negedge clk);
      #1;
      // R12 / R5: default configuration after clear
      chk("R12", pin_out, 1'b1);
      chk("R12", fb, 1'b0);
      aclr = 1'b0;

      // R1: combinational active-high follows the OR
      cfg = 4'b0011; pterm = '0; #1;
      chk("R1", pin_out, 1'b0);
      pterm = NPT'(1) << (NPT-1); #1;
      chk("R1", pin_out, 1'b1);
      pterm = NPT'(1); #1;
      chk("R1", pin_out, 1'b1);
      // R2: active-low inverts
      cfg = 4'b0010; #1;
      chk("R2", pin_out, 1'b0);

      // R3: registered capture, active-high then active-low
      cfg = 4'b0001; pterm = NPT'(4); tick(); #1;
      chk("R3", pin_out, 1'b1);
      chk("R10", fb, 1'b1);
      cfg = 4'b0000; #1;
      chk("R3", pin_out, 1'b0);

      // R4: preset sets register even with zero sum
      pterm = '0; spre = 1'b1; tick(); #1;
      chk("R4", fb, 1'b1);
      spre = 1'b0;

      // R5: clear empties register without an edge
      #1; aclr = 1'b1; #1;
      chk("R5", fb, 1'b0);
      mq = 1'b0;

      // R6: clear over preset across an edge
      spre = 1'b1; pterm = '1; tick(); #1;
      chk("R6", fb, 1'b0);
      aclr = 1'b0; spre = 1'b0;

      // R8: pin feedback with driver off, external level used
      cfg = 4'b0110; oe_term = 1'b0; pin_in = 1'b1; pterm = '0; #1;
      chk("R8", fb, 1'b1);
      chk("R7", pin_oe, 1'b0);
      pin_in = 1'b0; #1;
      chk("R8", fb, 1'b0);

      // R11: code 11 acts as pin feedback
      cfg = 4'b1100; pin_in = 1'b1; #1;
      chk("R11", fb, 1'b1);

      // R9: sum feedback ignores polarity
      cfg = 4'b1000; pterm = NPT'(2); #1;
      chk("R9", fb, 1'b1);
      tick();

      // Random phase
      for (int i = 0; i < 3000; i++) begin
         cfg     = 4'($urandom);
         pterm   = ($urandom % 2) ? NPT'($urandom) : '0;
         oe_term = 1'($urandom);
         pin_in  = 1'($urandom);
         spre    = ($urandom % 8) == 0;
         #1;
         check_all();
         tick();
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule